// File: doc/BRIEF.md
# ATM Cell Receive Checker

This block takes ATM cells from a byte-wide PHY-side receive interface. Each byte comes with a valid strobe, and a start-of-cell flag marks the first byte of a cell. The block frames 53-byte cells: four header bytes, one header check byte and 48 payload bytes. It recomputes the header check byte from the four header bytes and stores only complete cells whose check byte matches. It throws away cells cut short by an early start-of-cell. Bytes past the 53rd are dropped, so a cell that runs long is stored at 53 bytes. It also drops any arriving cell while its eight-cell store is full. Separate counters record header-check failures and overflow drops.

Stored cells leave in arrival order. A consumer sees `cell_ready` and pulses `rd_cell`. The block then streams the 53 bytes on consecutive cycles and flags the first byte.

A separate transmit path in the same block fills in the header check byte of outgoing cells. The byte in position 4 of each cell is replaced, with one cycle of latency.

Top module: `cell_rx_checker`

## Requirements
- R1: A receive byte is taken only when `rx_valid` is 1. A taken byte with `rx_soc` = 1 is byte index 0 of a new cell. Bytes taken before any start-of-cell, and inputs in cycles with `rx_valid` = 0, have no effect.
- R2: The header check byte (index 4) must equal the CRC-8 of bytes 0..3 XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1 (0x07), initial value 0, processed most significant bit first. A complete cell that fails this is not stored, and `hec_err_cnt` increases by 1 when its 53rd byte is taken.
- R3: If a start-of-cell is taken before the current cell reaches 53 bytes, the partial cell is discarded entirely and never becomes readable.
- R4: Bytes taken after the 53rd and before the next start-of-cell are discarded. The cell is stored as its first 53 bytes.
- R5: Up to 8 cells are stored and read out in arrival order. `cell_ready` is 1 while at least one stored cell has not been fully read out.
- R6: If all 8 cell stores are occupied when a start-of-cell is taken, that whole cell is dropped and `ovf_cnt` increases by 1.
- R7: A `rd_cell` pulse while `cell_ready` = 1 and no readout is in progress starts a readout. Starting on the next cycle, the oldest cell appears on `out_data` for 53 consecutive cycles with `out_valid` = 1, and `out_first` = 1 on byte 0 only. `rd_cell` during a readout or with no stored cell is ignored.
- R8: A cell becomes readable only after its 53rd byte is taken. `cell_ready` rises in the cycle after that byte, and not before.
- R9: The transmit path copies its inputs to its outputs one cycle later. In each cell that starts with `tx_in_soc`, the byte at index 4 is replaced by the header check byte of R2, computed over bytes 0..3 of that cell.
- R10: After reset both counters are zero, no cell is stored, and `out_valid` and `tx_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_soc | input | 1 | Receive byte is first of a cell |
| rx_data | input | 8 | Receive byte |
| rd_cell | input | 1 | Request readout of the oldest stored cell |
| cell_ready | output | 1 | At least one stored cell is pending |
| out_valid | output | 1 | Readout byte valid |
| out_first | output | 1 | Readout byte is byte 0 of a cell |
| out_data | output | 8 | Readout byte |
| hec_err_cnt | output | CNT_W | Header check failures (wrapping) |
| ovf_cnt | output | CNT_W | Cells dropped because the store was full (wrapping) |
| tx_in_valid | input | 1 | Transmit byte strobe |
| tx_in_soc | input | 1 | Transmit byte is first of a cell |
| tx_in_data | input | 8 | Transmit byte (index 4 is a placeholder) |
| tx_out_valid | output | 1 | Transmit output strobe |
| tx_out_soc | output | 1 | Transmit output first-of-cell flag |
| tx_out_data | output | 8 | Transmit byte with header check filled in |

## Verification
Framing is tried with several cell shapes:
- an exact 53-byte cell, which shows the framing and storage are correct;
- a cell with a corrupted check byte, which shows the check separates good headers from bad ones;
- a 20-byte and a 52-byte fragment, each followed by a good cell, which show that an early start-of-cell discards rather than merges;
- a 61-byte run, which shows clipping against counting the extra bytes as a new cell.

Directed sequences then cover the rest. Stray bytes before any start-of-cell and a start flag without valid show that only strobed bytes count. Splitting a cell at its 52nd byte shows exactly when `cell_ready` rises. Nine back-to-back cells show arrival order is kept and that the ninth cell is dropped rather than overwriting one. A transmit cell with an all-zero header pins the check byte to the known 0x55.

// File: rtl/cell_pkg.sv
// Shared constants and the header-check arithmetic for the cell receive checker.
// Assumes header check is CRC-8 (poly 0x07, init 0, MSB first) XOR coset 0x55.
package cell_pkg;
    localparam int         HDR_BYTES = 4;
    localparam logic [7:0] HEC_POLY  = 8'h07;
    localparam logic [7:0] HEC_COSET = 8'h55;

    // Advance the CRC-8 register over one byte, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/cell_rx_delin.sv
// Receive framing: tracks byte position from start-of-cell, checks the header
// check byte, decides per cell whether it is stored, and counts drops.
// Assumes buf_full is stable across the cycle and only falls during a cell.
module cell_rx_delin #(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(CELL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_soc,
    input  logic [7:0]       rx_data,
    input  logic             buf_full,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic [CNT_W-1:0] hec_err_cnt,
    output logic [CNT_W-1:0] ovf_cnt
);
    import cell_pkg::*;

    localparam int LAST = CELL_BYTES - 1;

    logic             active_q;
    logic             drop_q;
    logic             hec_bad_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       crc_q;
    logic             take_soc;
    logic             take_mid;
    logic             last_byte;

    // Classify the current byte: new cell, in-cell byte, or ignored.
    always_comb begin
        take_soc  = rx_valid && rx_soc;
        take_mid  = rx_valid && !rx_soc && active_q && (idx_q < IDX_W'(CELL_BYTES));
        last_byte = take_mid && (idx_q == IDX_W'(LAST));
    end

    // Drive the store's write port and the commit decision.
    always_comb begin
        wr_en   = (take_soc && !buf_full) || (take_mid && !drop_q);
        wr_idx  = take_soc ? '0 : idx_q;
        wr_data = rx_data;
        commit  = last_byte && !drop_q && !hec_bad_q;
    end

    // Track position, running CRC and per-cell drop/error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            drop_q    <= 1'b0;
            hec_bad_q <= 1'b0;
            idx_q     <= '0;
            crc_q     <= '0;
        end else if (take_soc) begin
            active_q  <= 1'b1;
            drop_q    <= buf_full;
            hec_bad_q <= 1'b0;
            idx_q     <= IDX_W'(1);
            crc_q     <= crc8_step(8'h00, rx_data);
        end else if (take_mid) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q < IDX_W'(HDR_BYTES)) begin
                crc_q <= crc8_step(crc_q, rx_data);
            end
            if (idx_q == IDX_W'(HDR_BYTES)) begin
                hec_bad_q <= (rx_data != (crc_q ^ HEC_COSET));
            end
        end
    end

    // Count header-check failures of complete cells and overflow drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hec_err_cnt <= '0;
            ovf_cnt     <= '0;
        end else begin
            if (last_byte && !drop_q && hec_bad_q) hec_err_cnt <= hec_err_cnt + 1'b1;
            if (take_soc && buf_full)              ovf_cnt     <= ovf_cnt + 1'b1;
        end
    end

    // R4: position never runs past one cell
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(CELL_BYTES));

    // R2: failure counter moves by one step at most
    a_r2_hec_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hec_err_cnt != $past(hec_err_cnt)) |-> (hec_err_cnt == $past(hec_err_cnt) + 1'b1));

    // R6: overflow counter moves only on a start-of-cell
    a_r6_ovf_on_soc: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt != $past(ovf_cnt)) |-> $past(rx_valid && rx_soc));
endmodule

// File: rtl/cell_buffer.sv
// Cell store: SLOTS cells of CELL_BYTES bytes kept in arrival order, with a
// burst readout of one whole cell per request. Assumes writes target only the
// slot after the newest committed one and that commit arrives only with room.
module cell_buffer #(
    parameter int CELL_BYTES = 53,
    parameter int SLOTS      = 8,
    localparam int IDX_W     = $clog2(CELL_BYTES + 1),
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W     = $clog2(SLOTS + 1),
    localparam int DEPTH     = CELL_BYTES * SLOTS,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic             rd_cell,
    output logic             full,
    output logic             cell_ready,
    output logic             out_valid,
    output logic             out_first,
    output logic [7:0]       out_data
);
    localparam int LAST = CELL_BYTES - 1;

    logic [7:0]        mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot_q;
    logic [SLOT_W-1:0] rd_slot_q;
    logic [CNT_W-1:0]  count_q;
    logic              busy_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              start;
    logic              pop;

    // Address arithmetic and readout control decisions.
    always_comb begin
        wr_addr = ADDR_W'(int'(wr_slot_q) * CELL_BYTES + int'(wr_idx));
        rd_addr = ADDR_W'(int'(rd_slot_q) * CELL_BYTES + int'(rd_idx_q));
        start   = rd_cell && !busy_q && (count_q != '0);
        pop     = busy_q && (rd_idx_q == IDX_W'(LAST));
    end

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Slot pointers and stored-cell count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot_q <= '0;
            rd_slot_q <= '0;
            count_q   <= '0;
        end else begin
            if (commit) wr_slot_q <= (int'(wr_slot_q) == SLOTS - 1) ? '0 : wr_slot_q + 1'b1;
            if (pop)    rd_slot_q <= (int'(rd_slot_q) == SLOTS - 1) ? '0 : rd_slot_q + 1'b1;
            count_q <= count_q + CNT_W'(commit) - CNT_W'(pop);
        end
    end

    // Readout sequencer: one byte per cycle for a whole cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rd_idx_q <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            rd_idx_q <= '0;
        end else if (busy_q) begin
            busy_q   <= !pop;
            rd_idx_q <= pop ? '0 : rd_idx_q + 1'b1;
        end
    end

    // Present status and the current readout byte.
    always_comb begin
        full       = (int'(count_q) == SLOTS);
        cell_ready = (count_q != '0);
        out_valid  = busy_q;
        out_first  = busy_q && (rd_idx_q == '0);
        out_data   = mem[rd_addr];
    end

    // R5: stored-cell count stays within the store size
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= SLOTS);

    // R6: framing never commits into a full store
    a_r6_commit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full);

    // R7: first-byte marker only on a valid byte
    a_r7_first_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    // R7: readout stops after the last byte of a cell
    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rd_idx_q == IDX_W'(LAST)) |=> !out_valid);
endmodule

// File: rtl/hec_tx_insert.sv
// Transmit header-check insertion: passes bytes through with one cycle of
// delay and replaces byte index 4 of each cell with the computed check byte.
// Assumes each cell starts with a start-of-cell flag on its byte 0.
module hec_tx_insert #(
    parameter int CELL_BYTES = 53,
    localparam int IDX_W     = $clog2(CELL_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_in_valid,
    input  logic       tx_in_soc,
    input  logic [7:0] tx_in_data,
    output logic       tx_out_valid,
    output logic       tx_out_soc,
    output logic [7:0] tx_out_data
);
    import cell_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       crc_q;

    // Position and running CRC of the outgoing cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_W'(CELL_BYTES);
            crc_q <= '0;
        end else if (tx_in_valid && tx_in_soc) begin
            idx_q <= IDX_W'(1);
            crc_q <= crc8_step(8'h00, tx_in_data);
        end else if (tx_in_valid && idx_q < IDX_W'(CELL_BYTES)) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q < IDX_W'(HDR_BYTES)) crc_q <= crc8_step(crc_q, tx_in_data);
        end
    end

    // Output register with check-byte substitution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_out_valid <= 1'b0;
            tx_out_soc   <= 1'b0;
            tx_out_data  <= '0;
        end else begin
            tx_out_valid <= tx_in_valid;
            tx_out_soc   <= tx_in_valid && tx_in_soc;
            if (tx_in_valid) begin
                if (!tx_in_soc && idx_q == IDX_W'(HDR_BYTES)) tx_out_data <= crc_q ^ HEC_COSET;
                else                                         tx_out_data <= tx_in_data;
            end
        end
    end

    // R9: every input byte appears at the output one cycle later
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_valid |=> tx_out_valid);
endmodule

// File: rtl/cell_rx_checker.sv
// Top: receive framing and header check feeding an eight-cell store with
// burst readout, plus the transmit header-check inserter.
// Assumes a single PHY on the receive side and no back-pressure at either edge.
module cell_rx_checker #(
    parameter int CELL_BYTES = 53,
    parameter int SLOTS      = 8,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(CELL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_soc,
    input  logic [7:0]       rx_data,
    input  logic             rd_cell,
    output logic             cell_ready,
    output logic             out_valid,
    output logic             out_first,
    output logic [7:0]       out_data,
    output logic [CNT_W-1:0] hec_err_cnt,
    output logic [CNT_W-1:0] ovf_cnt,
    input  logic             tx_in_valid,
    input  logic             tx_in_soc,
    input  logic [7:0]       tx_in_data,
    output logic             tx_out_valid,
    output logic             tx_out_soc,
    output logic [7:0]       tx_out_data
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic             commit;
    logic             buf_full;

    cell_rx_delin #(.CELL_BYTES(CELL_BYTES), .CNT_W(CNT_W)) delin_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_soc(rx_soc), .rx_data(rx_data),
        .buf_full(buf_full),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit),
        .hec_err_cnt(hec_err_cnt), .ovf_cnt(ovf_cnt)
    );

    cell_buffer #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit),
        .rd_cell(rd_cell), .full(buf_full), .cell_ready(cell_ready),
        .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
    );

    hec_tx_insert #(.CELL_BYTES(CELL_BYTES)) txins_i (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_soc(tx_in_soc), .tx_in_data(tx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_soc(tx_out_soc), .tx_out_data(tx_out_data)
    );

    // R8: a cell becomes readable only right after a commit
    a_r8_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_ready) |-> $past(commit));
endmodule

// File: tb/cell_rx_checker_tb_top.sv
module cell_rx_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_soc = 1'b0, rd_cell = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_in_valid = 1'b0, tx_in_soc = 1'b0;
    logic [7:0]  tx_in_data = 8'h00;
    logic        cell_ready, out_valid, out_first, tx_out_valid, tx_out_soc;
    logic [7:0]  out_data, tx_out_data;
    logic [15:0] hec_err_cnt, ovf_cnt;
    int n_checks = 0, n_errs = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cell_rx_checker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_soc(rx_soc), .rx_data(rx_data),
        .rd_cell(rd_cell), .cell_ready(cell_ready), .out_valid(out_valid),
        .out_first(out_first), .out_data(out_data), .hec_err_cnt(hec_err_cnt),
        .ovf_cnt(ovf_cnt), .tx_in_valid(tx_in_valid), .tx_in_soc(tx_in_soc),
        .tx_in_data(tx_in_data), .tx_out_valid(tx_out_valid), .tx_out_soc(tx_out_soc),
        .tx_out_data(tx_out_data)
    );

    // kind[17:16] (0 good, 1 bad check byte, 2 short, 3 long), length[15:8], seed[7:0]
    localparam logic [17:0] VEC [7] = '{
        {2'd0, 8'd53, 8'hA0}, {2'd1, 8'd53, 8'h11}, {2'd2, 8'd20, 8'h22},
        {2'd0, 8'd53, 8'h33}, {2'd3, 8'd61, 8'h44}, {2'd2, 8'd52, 8'h5A},
        {2'd0, 8'd53, 8'h66}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] r;
        logic fb;
        r = 8'h00;
        for (int b = 31; b >= 0; b--) begin
            fb = r[7] ^ h[b];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r ^ 8'h55;
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [7:0] s, input int i);
        return s + 8'(i * 17);
    endfunction

    function automatic logic [7:0] cbyte(input logic [7:0] s, input int i);
        if (i < 4) return hdr_byte(s, i);
        if (i == 4) return ref_hec({hdr_byte(s, 0), hdr_byte(s, 1), hdr_byte(s, 2), hdr_byte(s, 3)});
        return s ^ 8'(i);
    endfunction

    task automatic send_range(input logic [7:0] s, input int lo, input int hi, input bit bad);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_soc   = (i == 0);
            rx_data  = cbyte(s, i) ^ ((bad && i == 4) ? 8'h01 : 8'h00);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_soc   = 1'b1;     // start flag without valid must be ignored
        rx_data  = 8'hFF;
    endtask

    task automatic read_cell(input logic [7:0] s, input bit mid_pulse, input string tag);
        int mism = 0;
        @(negedge clk);
        rd_cell = 1'b1;
        @(negedge clk);
        rd_cell = 1'b0;
        for (int i = 0; i < 53; i++) begin
            if (out_valid !== 1'b1 || out_first !== (i == 0) || out_data !== cbyte(s, i)) mism++;
            if (mid_pulse) rd_cell = (i == 10);
            @(negedge clk);
        end
        rd_cell = 1'b0;
        chk({tag, " byte mismatches"}, mism, 0);
        chk({tag, " R7 valid low after last byte"}, int'(out_valid), 0);
    endtask

    task automatic tx_run(input logic [7:0] s, input bit zero_hdr);
        int mism = 0;
        logic [7:0] exp_q [53];
        logic [31:0] h;
        for (int i = 0; i < 4; i++) h[31 - 8*i -: 8] = zero_hdr ? 8'h00 : hdr_byte(s, i);
        for (int i = 0; i < 53; i++)
            exp_q[i] = (i < 4) ? h[31 - 8*i -: 8] : (i == 4) ? ref_hec(h) : cbyte(s, i);
        if (zero_hdr) chk("R9 reference check byte of zero header", int'(exp_q[4]), 'h55);
        for (int i = 0; i <= 53; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (tx_out_valid !== 1'b1 || tx_out_soc !== (i == 1) || tx_out_data !== exp_q[i-1]) mism++;
            end
            tx_in_valid = (i < 53);
            tx_in_soc   = (i == 0);
            tx_in_data  = (i == 4) ? 8'h00 : (i < 53 ? exp_q[i] : 8'h00);
        end
        chk("R9 transmit stream mismatches", mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [15:0] hec_before;
        repeat (3) @(negedge clk);
        chk("R10 cell_ready at reset", int'(cell_ready), 0);
        chk("R10 out_valid at reset", int'(out_valid), 0);
        chk("R10 hec_err_cnt at reset", int'(hec_err_cnt), 0);
        chk("R10 ovf_cnt at reset", int'(ovf_cnt), 0);
        chk("R10 tx_out_valid at reset", int'(tx_out_valid), 0);
        rst_n = 1'b1;

        // R1: strobed bytes with no start-of-cell are ignored
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_soc = 1'b0; rx_data = 8'(i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R1 no cell from bytes before start", int'(cell_ready), 0);

        // Table of cell shapes
        foreach (VEC[k]) begin
            hec_before = hec_err_cnt;
            send_range(VEC[k][7:0], 0, int'(VEC[k][15:8]), VEC[k][17:16] == 2'd1);
            case (VEC[k][17:16])
                2'd1: begin
                    chk("R2 bad check byte not stored", int'(cell_ready), 0);
                    chk("R2 hec_err_cnt increments", int'(hec_err_cnt), int'(hec_before) + 1);
                end
                2'd2: chk("R3 short cell not readable", int'(cell_ready), 0);
                2'd3: begin
                    read_cell(VEC[k][7:0], 1'b0, "R4 long cell clipped");
                    chk("R4 extra bytes form no cell", int'(cell_ready), 0);
                end
                default: begin
                    read_cell(VEC[k][7:0], 1'b0, "R1 R3 good cell");
                    chk("R3 fragment left nothing behind", int'(cell_ready), 0);
                    chk("R2 good cell leaves hec_err_cnt", int'(hec_err_cnt), int'(hec_before));
                end
            endcase
        end

        // R8: readiness only after the 53rd byte
        send_range(8'h77, 0, 52, 1'b0);
        chk("R8 not ready after 52 bytes", int'(cell_ready), 0);
        send_range(8'h77, 52, 53, 1'b0);
        chk("R8 ready after 53rd byte", int'(cell_ready), 1);
        read_cell(8'h77, 1'b0, "R8 split cell");

        // R7: request with nothing stored is ignored
        @(negedge clk); rd_cell = 1'b1;
        @(negedge clk); rd_cell = 1'b0;
        chk("R7 request on empty store ignored", int'(out_valid), 0);

        // R7: request during readout ignored; R5 order
        send_range(8'h81, 0, 53, 1'b0);
        send_range(8'h92, 0, 53, 1'b0);
        read_cell(8'h81, 1'b1, "R7 R5 first of two");
        chk("R7 second cell still pending", int'(cell_ready), 1);
        read_cell(8'h92, 1'b0, "R7 R5 second of two");

        // R6: overflow with nine cells; R5 order of eight
        for (int k = 0; k < 8; k++) send_range(8'(8'hC0 + k * 5), 0, 53, 1'b0);
        chk("R6 no overflow at eight cells", int'(ovf_cnt), 0);
        send_range(8'h3C, 0, 53, 1'b0);
        chk("R6 ovf_cnt after ninth cell", int'(ovf_cnt), 1);
        for (int k = 0; k < 8; k++) read_cell(8'(8'hC0 + k * 5), 1'b0, "R5 R6 stored order");
        chk("R6 ninth cell was dropped", int'(cell_ready), 0);

        // R9: transmit insertion
        tx_run(8'h5E, 1'b0);
        tx_run(8'h00, 1'b1);

        // R10: reset mid-operation clears state
        send_range(8'h21, 0, 53, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 store empty after reset", int'(cell_ready), 0);
        chk("R10 hec_err_cnt cleared", int'(hec_err_cnt), 0);
        chk("R10 ovf_cnt cleared", int'(ovf_cnt), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule